// File: doc/BRIEF.md
# Device Interrupt Steering Controller

This block steers interrupt requests from a set of device sources to processor targets. Each source owns one table entry that names a destination CPU and a vector number, together with an enable gate (the mask flag) and a sticky pending flag. A source whose mask is clear may fire; the block then masks it, sets its pending flag and places it in a post queue. The queue drains one source per cycle, lowest source index first. Each drained source produces a one-cycle post carrying the entry's CPU and vector as they stand when the post is issued.

Software reaches the table through a simple request/response register port. Each source has a routing register and a control register, both in 8-byte slots. After a source has fired it stays masked until software writes a control word that clears the mask. The same control write can also clear the pending flag. An access that hits neither register region returns zero and raises an error flag.

Top module: `irq_steer`

## Requirements
- R1: Routing register of source i sits at byte offset 8*i. A write stores CPU from bits 12:8 and vector from bits 5:0. A read returns those fields in the same positions, and every other bit reads as zero.
- R2: Control register of source i sits at byte offset 0x100 + 8*i. A read returns the mask flag in bit 2 and the pending flag in bit 0, and every other bit reads as zero.
- R3: A control write loads the mask flag from bit 2. Bit 1 set to 1 clears the pending flag. Bit 1 set to 0 leaves the pending flag as it was.
- R4: After reset, every entry has its mask flag set, its pending flag clear, and CPU and vector zero. No post and no response are active.
- R5: A request on a source whose mask flag is set changes no state and produces no post.
- R6: A request on an unmasked source sets its mask and pending flags and produces exactly one post with the entry's CPU and vector. Further requests from that source produce nothing until it is unmasked.
- R7: Sources accepted in the same cycle post on consecutive cycles, one post per cycle, in rising index order. Each post carries the routing values held in the cycle it is issued.
- R8: An access outside both register regions returns read data zero with the error flag set, and a write there changes no entry.
- R9: Every request cycle yields exactly one response cycle on the following clock. Read data reflects the state before that request's clock edge.
- R10: Without contention, a request sampled at clock edge k yields a one-cycle post visible after edge k+1.
- R11: If a source fires in the same cycle as a control write to its entry, the firing wins: mask and pending both end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_irq | input | NUM_SRC | Per-source interrupt request, level or pulse |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_rdata | output | DATA_W | Read data, zero for writes and errors |
| rsp_err | output | 1 | Access hit no register |
| post_valid | output | 1 | One-cycle interrupt post |
| post_cpu | output | CPU_W | Target CPU of the post |
| post_vec | output | VEC_W | Vector of the post |

## Verification
A corrupted mask flag shows up at the ports in one of two ways: a masked source posts, or a fired source posts again. A dropped pending bit shows up as a control read of the wrong value. Both are visible within two cycles of the offending request. A queue fault shows up as a missing, doubled or out-of-order post in the cycles after a multi-source burst. A routing fault shows up as a wrong CPU or vector on the next post or read-back. The bench steps a behavioural model in lockstep and compares every output on every cycle, so any such divergence is caught in the cycle it first reaches a port.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  // field positions shared by decode, entries and read mux
  localparam int RT_CPU_LSB  = 8;
  localparam int RT_VEC_LSB  = 0;
  localparam int CT_MASK_BIT = 2;
  localparam int CT_CLR_BIT  = 1;
  localparam int CT_PEND_BIT = 0;
  localparam int SLOT_SHIFT  = 3;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_ROUTE = 2'd1,
    SEL_CTRL  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_steer_decode.sv
module irq_steer_decode
  import irq_steer_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int ADDR_W   = 12,
  parameter int CTL_BASE = 'h100,
  parameter int IDX_W    = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W:0] SPAN   = (ADDR_W+1)'(NUM_SRC * 8);
  localparam logic [ADDR_W:0] CB     = (ADDR_W+1)'(CTL_BASE);
  localparam logic [ADDR_W:0] CE     = (ADDR_W+1)'(CTL_BASE + NUM_SRC * 8);

  logic [ADDR_W:0] a_ext;
  logic [ADDR_W:0] off;
  logic [ADDR_W:0] slot;
  logic            unused_ok;

  always_comb begin
    a_ext = {1'b0, addr};
    sel   = SEL_NONE;
    off   = '0;
    if (a_ext < SPAN) begin
      sel = SEL_ROUTE;
      off = a_ext;
    end else if (a_ext >= CB && a_ext < CE) begin
      sel = SEL_CTRL;
      off = a_ext - CB;
    end
    slot = off >> SLOT_SHIFT;
    idx  = slot[IDX_W-1:0];
  end

  assign unused_ok = ^{slot, off[SLOT_SHIFT-1:0]};
endmodule

// File: rtl/irq_steer_entry.sv
module irq_steer_entry
  import irq_steer_pkg::*;
#(
  parameter int CPU_W  = 5,
  parameter int VEC_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq,
  input  logic              rt_we,
  input  logic              ct_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [CPU_W-1:0]  cpu,
  output logic [VEC_W-1:0]  vec,
  output logic              mask,
  output logic              pend,
  output logic              fire
);
  logic unused_ok;

  assign fire = irq & ~mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu  <= '0;
      vec  <= '0;
      mask <= 1'b1;
      pend <= 1'b0;
    end else begin
      if (rt_we) begin
        cpu <= wdata[RT_CPU_LSB +: CPU_W];
        vec <= wdata[RT_VEC_LSB +: VEC_W];
      end
      // an accepted request outranks a same-cycle control write
      if (fire) begin
        mask <= 1'b1;
        pend <= 1'b1;
      end else if (ct_we) begin
        mask <= wdata[CT_MASK_BIT];
        if (wdata[CT_CLR_BIT]) pend <= 1'b0;
      end
    end
  end

  assign unused_ok = ^wdata;
endmodule

// File: rtl/irq_steer_post.sv
module irq_steer_post #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3,
  parameter int CPU_W   = 5,
  parameter int VEC_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] fire,
  input  logic [CPU_W-1:0]   cpu_tab [NUM_SRC],
  input  logic [VEC_W-1:0]   vec_tab [NUM_SRC],
  output logic [NUM_SRC-1:0] queue,
  output logic               post_valid,
  output logic [CPU_W-1:0]   post_cpu,
  output logic [VEC_W-1:0]   post_vec
);
  logic               found;
  logic [IDX_W-1:0]   gidx;
  logic [NUM_SRC-1:0] grant;

  // lowest set queue bit wins
  always_comb begin
    found = 1'b0;
    gidx  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (queue[i]) begin
        found = 1'b1;
        gidx  = IDX_W'(i);
      end
    end
    grant = found ? (NUM_SRC'(1) << gidx) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      queue      <= '0;
      post_valid <= 1'b0;
      post_cpu   <= '0;
      post_vec   <= '0;
    end else begin
      queue      <= (queue & ~grant) | fire;
      post_valid <= found;
      post_cpu   <= found ? cpu_tab[gidx] : '0;
      post_vec   <= found ? vec_tab[gidx] : '0;
    end
  end
endmodule

// File: rtl/irq_steer.sv
module irq_steer
  import irq_steer_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int CPU_W    = 5,
  parameter int VEC_W    = 6,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int CTL_BASE = 'h100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] dev_irq,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_err,
  output logic               post_valid,
  output logic [CPU_W-1:0]   post_cpu,
  output logic [VEC_W-1:0]   post_vec
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  reg_sel_e           sel;
  logic [IDX_W-1:0]   idx;
  logic [CPU_W-1:0]   cpu_tab [NUM_SRC];
  logic [VEC_W-1:0]   vec_tab [NUM_SRC];
  logic [NUM_SRC-1:0] mask_vec;
  logic [NUM_SRC-1:0] pend_vec;
  logic [NUM_SRC-1:0] fire_vec;
  logic [NUM_SRC-1:0] queue_vec;
  logic [DATA_W-1:0]  rd_data;
  logic               wr_go;

  irq_steer_decode #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .CTL_BASE(CTL_BASE), .IDX_W(IDX_W)
  ) u_dec (
    .addr(req_addr), .sel(sel), .idx(idx)
  );

  assign wr_go = req_valid & req_write;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_ent
    irq_steer_entry #(
      .CPU_W(CPU_W), .VEC_W(VEC_W), .DATA_W(DATA_W)
    ) u_ent (
      .clk   (clk),
      .rst   (rst),
      .irq   (dev_irq[g]),
      .rt_we (wr_go && sel == SEL_ROUTE && idx == IDX_W'(g)),
      .ct_we (wr_go && sel == SEL_CTRL  && idx == IDX_W'(g)),
      .wdata (req_wdata),
      .cpu   (cpu_tab[g]),
      .vec   (vec_tab[g]),
      .mask  (mask_vec[g]),
      .pend  (pend_vec[g]),
      .fire  (fire_vec[g])
    );
  end

  irq_steer_post #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .CPU_W(CPU_W), .VEC_W(VEC_W)
  ) u_post (
    .clk        (clk),
    .rst        (rst),
    .fire       (fire_vec),
    .cpu_tab    (cpu_tab),
    .vec_tab    (vec_tab),
    .queue      (queue_vec),
    .post_valid (post_valid),
    .post_cpu   (post_cpu),
    .post_vec   (post_vec)
  );

  always_comb begin
    rd_data = '0;
    case (sel)
      SEL_ROUTE: begin
        rd_data[RT_CPU_LSB +: CPU_W] = cpu_tab[idx];
        rd_data[RT_VEC_LSB +: VEC_W] = vec_tab[idx];
      end
      SEL_CTRL: begin
        rd_data[CT_MASK_BIT] = mask_vec[idx];
        rd_data[CT_PEND_BIT] = pend_vec[idx];
      end
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_data : '0;
      rsp_err   <= req_valid && sel == SEL_NONE;
    end
  end
endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk #(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] dev_irq,
  input logic               req_valid,
  input logic               rsp_valid,
  input logic               rsp_err,
  input logic [DATA_W-1:0]  rsp_rdata,
  input logic               post_valid,
  input logic [NUM_SRC-1:0] mask_vec,
  input logic [NUM_SRC-1:0] pend_vec,
  input logic [NUM_SRC-1:0] queue_vec
);
  a_r9_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r9_no_stray_rsp: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r8_err_reads_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_valid && rsp_rdata == '0));

  a_r10_post_needs_queue: assert property (@(posedge clk) disable iff (rst)
    post_valid |-> $past(queue_vec) != '0);

  a_r4_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&mask_vec) && pend_vec == '0);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    a_r6_fire_sets_flags: assert property (@(posedge clk) disable iff (rst)
      dev_irq[g] && !mask_vec[g] |=> mask_vec[g] && pend_vec[g] && queue_vec[g]);

    a_r5_masked_no_effect: assert property (@(posedge clk) disable iff (rst)
      dev_irq[g] && mask_vec[g] && !req_valid |=> mask_vec[g] && $stable(pend_vec[g]));
  end
endmodule

bind irq_steer irq_steer_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dev_irq    (dev_irq),
  .req_valid  (req_valid),
  .rsp_valid  (rsp_valid),
  .rsp_err    (rsp_err),
  .rsp_rdata  (rsp_rdata),
  .post_valid (post_valid),
  .mask_vec   (mask_vec),
  .pend_vec   (pend_vec),
  .queue_vec  (queue_vec)
);

// File: tb/irq_steer_bench.sv
module irq_steer_bench;
  localparam int N  = 8;
  localparam int AW = 12;
  localparam int CB = 'h100;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq = '0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid, rsp_err, post_valid;
  logic [31:0]   rsp_rdata;
  logic [4:0]    post_cpu;
  logic [5:0]    post_vec;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  irq_steer u_irq_steer (
    .clk(clk), .rst(rst), .dev_irq(irq),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .post_valid(post_valid), .post_cpu(post_cpu),
    .post_vec(post_vec)
  );

  always #2 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cpu[N], m_vec[N], o_cpu[N], o_vec[N];
  bit m_mask[N], m_pend[N], m_q[N], o_mask[N], o_pend[N], o_q[N];
  bit e_rv, e_re, e_pv;
  int e_rd, e_pc, e_pvec;

  always @(posedge clk) begin
    int a, ri, g;
    cyc++;
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_cpu[i] = 0; m_vec[i] = 0; m_mask[i] = 1; m_pend[i] = 0; m_q[i] = 0;
      end
      e_rv = 0; e_re = 0; e_rd = 0; e_pv = 0; e_pc = 0; e_pvec = 0;
    end else begin
      o_cpu = m_cpu; o_vec = m_vec; o_mask = m_mask; o_pend = m_pend; o_q = m_q;
      e_rv = req_valid; e_rd = 0; e_re = 0;
      if (req_valid) begin
        a = int'(req_addr);
        if (a < N * 8) begin
          ri = a / 8;
          if (!req_write) e_rd = (o_cpu[ri] << 8) | o_vec[ri];
          else begin
            m_cpu[ri] = int'((req_wdata >> 8) & 32'h1f);
            m_vec[ri] = int'(req_wdata & 32'h3f);
          end
        end else if (a >= CB && a < CB + N * 8) begin
          ri = (a - CB) / 8;
          if (!req_write) e_rd = (o_mask[ri] ? 4 : 0) | (o_pend[ri] ? 1 : 0);
          else begin
            m_mask[ri] = req_wdata[2];
            if (req_wdata[1]) m_pend[ri] = 0;
          end
        end else e_re = 1;
      end
      g = -1;
      for (int i = N - 1; i >= 0; i--) if (o_q[i]) g = i;
      e_pv   = (g >= 0);
      e_pc   = (g >= 0) ? o_cpu[g] : 0;
      e_pvec = (g >= 0) ? o_vec[g] : 0;
      if (g >= 0) m_q[g] = 0;
      for (int i = 0; i < N; i++)
        if (irq[i] && !o_mask[i]) begin
          m_mask[i] = 1; m_pend[i] = 1; m_q[i] = 1;
        end
    end
  end

  // lockstep compare and post log
  int plog_cpu[512], plog_vec[512], plog_t[512];
  int pn = 0;

  always @(negedge clk) begin
    if (cyc > 0 && !done) begin
      chk("R9 rsp_valid", 32'(rsp_valid), 32'(e_rv));
      chk("R1 R2 R9 rsp_rdata", rsp_rdata, e_rd);
      chk("R8 rsp_err", 32'(rsp_err), 32'(e_re));
      chk("R6 R7 R10 post_valid", 32'(post_valid), 32'(e_pv));
      chk("R6 R7 post_cpu", 32'(post_cpu), e_pc);
      chk("R6 R7 post_vec", 32'(post_vec), e_pvec);
    end
    if (post_valid && pn < 512) begin
      plog_cpu[pn] = post_cpu; plog_vec[pn] = post_vec; plog_t[pn] = cyc; pn++;
    end
  end

  task automatic wr(int addr, logic [31:0] data);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = AW'(addr); req_wdata = data;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(int addr, logic [31:0] exp, string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = AW'(addr);
    @(negedge clk);
    req_valid = 0;
    chk(tag, rsp_rdata, exp);
  endtask

  task automatic pulse(logic [N-1:0] m);
    @(negedge clk); irq = m;
    @(negedge clk); irq = '0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int base, c0;
    repeat (3) @(negedge clk);
    rst = 0;

    rd(CB + 0, 32'h4, "R4 ctl reset");
    rd(8 * 3, 32'h0, "R4 routing reset");

    wr(8 * 2, 32'hffff_ffff);
    rd(8 * 2, 32'h1f3f, "R1 field masking");

    base = pn; pulse(8'h04); repeat (3) @(negedge clk);
    chk("R5 masked no post", pn - base, 0);
    rd(CB + 8 * 2, 32'h4, "R5 masked state held");

    wr(8 * 2, 32'h0000_0509);
    wr(CB + 8 * 2, 32'h0);
    rd(CB + 8 * 2, 32'h0, "R3 unmask");

    base = pn;
    @(negedge clk); irq = 8'h04; c0 = cyc;
    @(negedge clk); irq = '0;
    repeat (3) @(negedge clk);
    chk("R6 one post", pn - base, 1);
    chk("R6 post cpu", plog_cpu[base], 5);
    chk("R6 post vec", plog_vec[base], 9);
    chk("R10 post latency", plog_t[base] - c0, 2);
    rd(CB + 8 * 2, 32'h5, "R6 mask and pending set");

    base = pn;
    @(negedge clk); irq = 8'h04;
    repeat (5) @(negedge clk);
    irq = '0;
    chk("R6 auto-mask blocks repost", pn - base, 0);

    wr(CB + 8 * 2, 32'h4);
    rd(CB + 8 * 2, 32'h5, "R3 bit1 low keeps pending");
    wr(CB + 8 * 2, 32'h6);
    rd(CB + 8 * 2, 32'h4, "R3 bit1 high clears pending");

    wr(8 * 1, 32'h0101); wr(8 * 4, 32'h0404); wr(8 * 6, 32'h0606);
    wr(CB + 8 * 1, 0); wr(CB + 8 * 4, 0); wr(CB + 8 * 6, 0);
    base = pn; pulse(8'b0101_0010); repeat (5) @(negedge clk);
    chk("R7 post count", pn - base, 3);
    chk("R7 first lowest", plog_cpu[base], 1);
    chk("R7 second", plog_cpu[base + 1], 4);
    chk("R7 third", plog_vec[base + 2], 6);
    chk("R7 back to back", plog_t[base + 2] - plog_t[base], 2);

    rd('h80, 32'h0, "R8 unmapped read data");
    chk("R8 unmapped err flag", 32'(rsp_err), 1);
    wr('h300, 32'hffff_ffff);
    rd(8 * 1, 32'h0101, "R8 unmapped write ignored");
    rd(CB + 8 * 1, 32'h5, "R8 ctl untouched");

    wr(CB + 8 * 3, 0);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = AW'(CB + 8 * 3); req_wdata = 32'h2;
    irq = 8'h08;
    @(negedge clk);
    req_valid = 0; req_write = 0; irq = '0;
    rd(CB + 8 * 3, 32'h5, "R11 fire beats write");

    for (int k = 0; k < 600; k++) begin
      int r;
      @(negedge clk);
      irq = N'($urandom) & N'($urandom);
      r = int'($urandom % 8);
      if (r < 3) begin
        req_valid = 1; req_write = (r != 0);
        req_addr  = AW'(((r == 2) ? CB : 0) + int'($urandom % 8) * 8);
        req_wdata = (r == 2) ? 32'($urandom % 4) : $urandom;
      end else if (r == 3) begin
        req_valid = 1; req_write = $urandom % 2; req_addr = AW'('h200 + k);
        req_wdata = $urandom;
      end else begin
        req_valid = 0; req_write = 0;
      end
    end
    @(negedge clk);
    irq = '0; req_valid = 0; req_write = 0;
    repeat (12) @(negedge clk);

    done = 1;
    summary();
    $finish;
  end
endmodule